// File: doc/BRIEF.md
# Push-Button Wiper Position Controller

This block turns two active-high push-button inputs, one for up and one for down, into single steps of a wiper position register. Contact bounce is filtered by measuring how long each high level lasts. A level must stay high for a set number of millisecond ticks before it counts as a press.

If a button is held much longer, the block switches to auto-repeat and keeps stepping at a fixed interval until the button is released. The position has two extra states beyond the normal 6-bit range: a bottom-scale state below code 0 and a top-scale state above code 63.

Time is measured with a one-cycle 1 ms tick-enable input, and every duration is a parameter. A lock input freezes both buttons, for example while a storage write is in progress. A restore strobe loads a saved position after power-up. The outputs are the position, an end-scale flag and a one-cycle pulse on every accepted step.

Top module: `pb_wiper_ctrl`

## Requirements
- R1: After reset the position is 0x20 (midscale), end_scale is 0 and step_pulse is 0.
- R2: The position is 7 bits wide. Codes 0 to 63 are 0x00 to 0x3F, the top-scale state is 0x40 and the bottom-scale state is 0x7F. No other value ever appears.
- R3: A button whose high level lasts fewer than DEB_MS ticks produces no step. When the high level reaches DEB_MS ticks, exactly one step is taken on that tick.
- R4: An up step adds one to the code and a down step subtracts one. Both buttons are timed the same way.
- R5: A press held for HOLD_MS ticks enters auto-scan. Further steps then fall on ticks HOLD_MS+STEP_MS, HOLD_MS+2*STEP_MS, and so on until release.
- R6: A down step from code 0 enters bottom-scale and an up step from code 63 enters top-scale. An up step from bottom-scale returns to code 0, and a down step from top-scale returns to code 63.
- R7: A down step in bottom-scale and an up step in top-scale change nothing and give no pulse.
- R8: While both buttons are high, no step is taken and both press timers are cleared.
- R9: While lock is high, both buttons are ignored and both press timers are cleared.
- R10: step_pulse is high for exactly one cycle, in the cycle after each accepted step, when the new position is already visible.
- R11: end_scale is high exactly when the position is 0x7F or 0x40.
- R12: A restore_vld cycle loads {0, restore_code} into the position. It takes priority over a step in the same cycle, gives no pulse and is not blocked by lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle 1 ms time-base enable |
| btn_up | input | 1 | Up button, active high |
| btn_dn | input | 1 | Down button, active high |
| lock | input | 1 | Ignore buttons and clear press timers |
| restore_vld | input | 1 | Load restore_code into the position |
| restore_code | input | 6 | Saved position code to restore |
| pos | output | 7 | Wiper position (see R2 encoding) |
| end_scale | output | 1 | Position is in bottom-scale or top-scale |
| step_pulse | output | 1 | One-cycle pulse per accepted step |

## Verification
The bench builds the block with DEB_MS=3, HOLD_MS=20 and STEP_MS=5 instead of 8, 1000 and 140. With these values, a bounce shorter than the debounce window, the switch into auto-scan and several auto-repeat steps all fit into a few dozen ticks. A tick is issued every second clock, so every accepted step can be checked for a pulse in one cycle and its absence in the next. Restores place the position next to code 0 and code 63, so that both extra scale states and their exits are reached within a few presses.

// File: rtl/pb_wiper_pkg.sv
package pb_wiper_pkg;
  localparam int CODE_W = 6;
  localparam int POS_W  = CODE_W + 1;
  typedef logic [POS_W-1:0] pos_t;

  localparam pos_t POS_BOT  = {POS_W{1'b1}};
  localparam pos_t POS_TOP  = pos_t'(1) << CODE_W;
  localparam pos_t POS_MAXC = POS_TOP - pos_t'(1);
  localparam pos_t POS_MID  = pos_t'(1) << (CODE_W - 1);

  // next position for an up step
  function automatic pos_t pos_inc(input pos_t p);
    if (p == POS_BOT)       return '0;
    else if (p >= POS_MAXC) return POS_TOP;
    else                    return p + pos_t'(1);
  endfunction

  // next position for a down step
  function automatic pos_t pos_dec(input pos_t p);
    if (p == POS_TOP)            return POS_MAXC;
    else if (p == '0 || p == POS_BOT) return POS_BOT;
    else                         return p - pos_t'(1);
  endfunction

  function automatic logic is_end(input pos_t p);
    return (p == POS_BOT) || (p == POS_TOP);
  endfunction
endpackage

// File: rtl/pb_press_timer.sv
module pb_press_timer #(
  parameter int DEB_MS  = 8,
  parameter int HOLD_MS = 1000,
  parameter int STEP_MS = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic active,
  output logic fire
);
  localparam int HW = $clog2(HOLD_MS + 1);
  localparam int SW = $clog2(STEP_MS + 1);
  localparam logic [HW-1:0] HOLD_C = HW'(HOLD_MS);
  localparam logic [HW-1:0] DEB_C  = HW'(DEB_MS);
  localparam logic [SW-1:0] STEP_L = SW'(STEP_MS - 1);

  logic [HW-1:0] hold_cnt;
  logic [SW-1:0] scan_cnt;
  logic          in_scan;
  logic          deb_hit;
  logic          scan_hit;

  assign in_scan  = (hold_cnt == HOLD_C);
  assign deb_hit  = !in_scan && (hold_cnt + HW'(1) == DEB_C);
  assign scan_hit = in_scan && (scan_cnt == STEP_L);
  assign fire     = active && tick_ms && (deb_hit || scan_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      scan_cnt <= '0;
    end else if (!active) begin
      hold_cnt <= '0;
      scan_cnt <= '0;
    end else if (tick_ms) begin
      if (!in_scan)      hold_cnt <= hold_cnt + HW'(1);
      else if (scan_hit) scan_cnt <= '0;
      else               scan_cnt <= scan_cnt + SW'(1);
    end
  end
endmodule

// File: rtl/pb_pos_reg.sv
module pb_pos_reg
  import pb_wiper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic load,
  input  pos_t load_val,
  output pos_t pos,
  output logic pulse
);
  pos_t nxt;
  logic moved;

  always_comb begin
    nxt = pos;
    if (inc)      nxt = pos_inc(pos);
    else if (dec) nxt = pos_dec(pos);
    moved = (nxt != pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= POS_MID;
      pulse <= 1'b0;
    end else if (load) begin
      pos   <= load_val;
      pulse <= 1'b0;
    end else begin
      pos   <= nxt;
      pulse <= moved;
    end
  end
endmodule

// File: rtl/pb_wiper_ctrl.sv
module pb_wiper_ctrl
  import pb_wiper_pkg::*;
#(
  parameter int DEB_MS  = 8,
  parameter int HOLD_MS = 1000,
  parameter int STEP_MS = 140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              btn_up,
  input  logic              btn_dn,
  input  logic              lock,
  input  logic              restore_vld,
  input  logic [CODE_W-1:0] restore_code,
  output logic [POS_W-1:0]  pos,
  output logic              end_scale,
  output logic              step_pulse
);
  logic [1:0] btn_v;
  logic [1:0] act_v;
  logic [1:0] fire_v;
  logic       up_evt;
  logic       dn_evt;
  pos_t       pos_q;

  assign btn_v = {btn_dn, btn_up};

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_btn
      assign act_v[gi] = btn_v[gi] && !btn_v[1-gi] && !lock;
      pb_press_timer #(
        .DEB_MS (DEB_MS),
        .HOLD_MS(HOLD_MS),
        .STEP_MS(STEP_MS)
      ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_ms(tick_ms),
        .active (act_v[gi]),
        .fire   (fire_v[gi])
      );
    end
  endgenerate

  assign up_evt = fire_v[0];
  assign dn_evt = fire_v[1];

  pb_pos_reg i_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (up_evt),
    .dec     (dn_evt),
    .load    (restore_vld),
    .load_val({1'b0, restore_code}),
    .pos     (pos_q),
    .pulse   (step_pulse)
  );

  assign pos       = pos_q;
  assign end_scale = is_end(pos_q);
endmodule

// File: rtl/pb_wiper_chk.sv
module pb_wiper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       btn_up,
  input logic       btn_dn,
  input logic       lock,
  input logic       restore_vld,
  input logic [6:0] pos,
  input logic       step_pulse,
  input logic       up_evt,
  input logic       dn_evt
);
  a_r2_legal_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (pos <= 7'h40) || (pos == 7'h7F));

  a_r8_both_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_up && btn_dn && !restore_vld) |=> ($stable(pos) && !step_pulse));

  a_r9_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !restore_vld) |=> ($stable(pos) && !step_pulse));

  a_r10_pulse_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse || $past(up_evt || dn_evt));

  a_r7_bottom_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == 7'h7F && dn_evt && !restore_vld) |=> (pos == 7'h7F && !step_pulse));

  a_r7_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == 7'h40 && up_evt && !restore_vld) |=> (pos == 7'h40 && !step_pulse));
endmodule

bind pb_wiper_ctrl pb_wiper_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .btn_up     (btn_up),
  .btn_dn     (btn_dn),
  .lock       (lock),
  .restore_vld(restore_vld),
  .pos        (pos),
  .step_pulse (step_pulse),
  .up_evt     (up_evt),
  .dn_evt     (dn_evt)
);

// File: tb/test_pb_wiper_ctrl.sv
module test_pb_wiper_ctrl;
  localparam int DEB  = 3;
  localparam int HOLD = 20;
  localparam int STEP = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b0;
  logic       btn_up = 1'b0;
  logic       btn_dn = 1'b0;
  logic       lock = 1'b0;
  logic       restore_vld = 1'b0;
  logic [5:0] restore_code = '0;
  logic [6:0] pos;
  logic       end_scale;
  logic       step_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int hc[2];
  int sc[2];
  logic [6:0] mpos;

  always #2 clk = ~clk;

  pb_wiper_ctrl #(.DEB_MS(DEB), .HOLD_MS(HOLD), .STEP_MS(STEP)) i_pb_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_up(btn_up), .btn_dn(btn_dn),
    .lock(lock), .restore_vld(restore_vld), .restore_code(restore_code),
    .pos(pos), .end_scale(end_scale), .step_pulse(step_pulse)
  );

  function automatic logic [6:0] m_up(input logic [6:0] p);
    case (p)
      7'h7F:   return 7'h00;
      7'h3F:   return 7'h40;
      7'h40:   return 7'h40;
      default: return p + 7'd1;
    endcase
  endfunction

  function automatic logic [6:0] m_dn(input logic [6:0] p);
    case (p)
      7'h00:   return 7'h7F;
      7'h7F:   return 7'h7F;
      7'h40:   return 7'h3F;
      default: return p - 7'd1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one millisecond: two clocks, tick in the first
  task automatic ms(input string tag, input logic u, input logic d, input logic l,
                    input logic rv = 1'b0, input logic [5:0] rc = 6'd0);
    logic fire[2];
    logic ep;
    logic [6:0] np;
    @(negedge clk);
    btn_up = u; btn_dn = d; lock = l; tick_ms = 1'b1;
    restore_vld = rv; restore_code = rc;
    for (int b = 0; b < 2; b++) begin
      logic me;
      logic ot;
      me = (b == 0) ? u : d;
      ot = (b == 0) ? d : u;
      fire[b] = 1'b0;
      if (!(me && !ot && !l)) begin
        hc[b] = 0; sc[b] = 0;
      end else if (hc[b] < HOLD) begin
        hc[b]++;
        if (hc[b] == DEB) fire[b] = 1'b1;
      end else begin
        sc[b]++;
        if (sc[b] == STEP) begin fire[b] = 1'b1; sc[b] = 0; end
      end
    end
    ep = 1'b0;
    if (rv) mpos = {1'b0, rc};
    else if (fire[0] || fire[1]) begin
      np = fire[0] ? m_up(mpos) : m_dn(mpos);
      if (np != mpos) begin ep = 1'b1; mpos = np; end
    end
    @(posedge clk);
    @(negedge clk);
    tick_ms = 1'b0; restore_vld = 1'b0;
    chk({tag, " pos"}, 32'(pos), 32'(mpos));
    chk({tag, " pulse"}, 32'(step_pulse), 32'(ep));
    chk("R11 end_scale", 32'(end_scale), 32'((mpos == 7'h7F) || (mpos == 7'h40)));
    @(posedge clk);
    @(negedge clk);
    chk("R10 pulse width", 32'(step_pulse), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic u, d, l;
    void'($urandom(32'd4711));
    hc[0] = 0; hc[1] = 0; sc[0] = 0; sc[1] = 0;
    mpos = 7'h20;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pos", 32'(pos), 32'h20);
    chk("R1 reset end", 32'(end_scale), 32'd0);
    chk("R1 reset pulse", 32'(step_pulse), 32'd0);
    rst_n = 1'b1;

    // R3 bounce shorter than debounce window
    for (int i = 0; i < DEB - 1; i++) ms("R3 bounce", 1, 0, 0);
    ms("R3 release", 0, 0, 0);
    chk("R3 no step on bounce", 32'(pos), 32'h20);
    // R3/R4 valid presses
    for (int i = 0; i < DEB + 2; i++) ms("R3 press up", 1, 0, 0);
    ms("R4 release", 0, 0, 0);
    chk("R4 up one", 32'(pos), 32'h21);
    for (int i = 0; i < DEB; i++) ms("R4 press dn", 0, 1, 0);
    ms("R4 release", 0, 0, 0);
    chk("R4 down one", 32'(pos), 32'h20);

    // R5 auto-scan: 3 more steps after entering scan
    for (int i = 0; i < HOLD + 3 * STEP; i++) ms("R5 auto-scan", 1, 0, 0);
    ms("R5 release", 0, 0, 0);
    chk("R5 four steps", 32'(pos), 32'h24);

    // R6/R7 bottom
    ms("R12 restore", 0, 0, 0, 1, 6'd1);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < DEB; i++) ms("R6 down to bottom", 0, 1, 0);
      ms("R6 release", 0, 0, 0);
    end
    chk("R7 bottom held", 32'(pos), 32'h7F);
    for (int i = 0; i < DEB; i++) ms("R6 exit bottom", 1, 0, 0);
    ms("R6 release", 0, 0, 0);
    chk("R6 bottom to zero", 32'(pos), 32'h00);

    // R6/R7 top via auto-scan
    ms("R12 restore", 0, 0, 0, 1, 6'd62);
    for (int i = 0; i < HOLD + 2 * STEP; i++) ms("R7 scan into top", 1, 0, 0);
    ms("R6 release", 0, 0, 0);
    chk("R7 top held", 32'(pos), 32'h40);
    for (int i = 0; i < DEB; i++) ms("R6 exit top", 0, 1, 0);
    ms("R6 release", 0, 0, 0);
    chk("R6 top to 63", 32'(pos), 32'h3F);

    // R8 both high clears timers
    for (int i = 0; i < DEB - 1; i++) ms("R8 partial up", 1, 0, 0);
    ms("R8 both high", 1, 1, 0);
    for (int i = 0; i < DEB - 1; i++) ms("R8 timer cleared", 1, 0, 0);
    chk("R8 no step", 32'(pos), 32'h3F);
    ms("R8 completes", 1, 0, 0);
    ms("R8 release", 0, 0, 0);

    // R9 lock
    for (int i = 0; i < DEB + 4; i++) ms("R9 locked", 0, 1, 1);
    chk("R9 lock ignores", 32'(pos), 32'h40);
    for (int i = 0; i < DEB - 1; i++) ms("R9 partial", 0, 1, 0);
    ms("R9 lock clears", 0, 1, 1);
    for (int i = 0; i < DEB - 1; i++) ms("R9 timer cleared", 0, 1, 0);
    ms("R9 release", 0, 0, 0);

    // R12 restore priority over a step, and under lock
    for (int i = 0; i < DEB - 1; i++) ms("R12 pre", 1, 0, 0);
    ms("R12 restore beats step", 1, 0, 0, 1, 6'd10);
    ms("R12 restore under lock", 0, 0, 1, 1, 6'd40);
    chk("R12 loaded", 32'(pos), 32'h28);
    ms("R12 release", 0, 0, 0);

    // R2 random stimulus with held patterns
    for (int k = 0; k < 120; k++) begin
      int len;
      int r;
      r = $urandom_range(0, 9);
      u = (r < 4); d = (r >= 4 && r < 8); l = (r == 8);
      if (r == 9) begin u = 1; d = 1; end
      len = $urandom_range(1, 30);
      for (int i = 0; i < len; i++) ms("R2 random", u, d, l);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule